// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write-Protect Guard

This block keeps the status register of a serial EEPROM and makes every write-permission decision for the memory engine that sits beside it. The engine decodes the serial commands and hands this block one-cycle pulses: set the write-enable latch, clear it, commit a status write (with its data byte), and report that an array write has finished. In return the block gives the engine the status byte to shift out on a status read, a flag that says whether the address under test may be written, and a flag that says whether a status write would be accepted.

Two independent protection mechanisms are combined. Two block-protect bits select a protected upper region of the array: nothing, the top quarter, the top half or the whole array. A separate enable bit arms the active-low write-protect pin. While both are asserted, the status register is frozen, but array writes outside the protected region are still allowed. Non-volatile bits are modelled as ordinary flops that reset to zero.

Top module: `eeprom_guard`

## Requirements
- R1: `statusByte` reads bit 7 = protect-pin enable, bits 6:4 = 0, bit 3 = block-protect high, bit 2 = block-protect low, bit 1 = write-enable latch, bit 0 = `busy`.
- R2: After reset the latch, the protect-pin enable and both block-protect bits are 0.
- R3: A `cmdSetLatch` pulse sets the latch on the next cycle, a `cmdClrLatch` pulse clears it; when both arrive together the latch is cleared.
- R4: Set and clear pulses update the latch whatever the protect-pin state and the block-protect bits are.
- R5: `statusWritable` is 1 exactly when the latch is 1, `busy` is 0, and not (protect-pin enable is 1 and `wpN` is 0).
- R6: A `cmdStatusWrite` pulse while `statusWritable` is 1 loads data bits 7, 3 and 2 into the register on the next cycle and clears the latch; data bits 6:4, 1 and 0 are ignored.
- R7: A `cmdStatusWrite` pulse while `statusWritable` is 0 changes neither the stored bits nor the latch.
- R8: `arrayWritable` is 1 exactly when the latch is 1, `busy` is 0 and `checkAddr` lies outside the protected region: block-protect 00 protects nothing, 01 protects addresses whose two top bits are 11 (0x600-0x7FF at 11 bits), 10 those whose top bit is 1 (0x400-0x7FF), 11 protects every address.
- R9: An `arrayWriteDone` pulse clears the latch on the next cycle, whatever `wpN` is doing.
- R10: With the protect pin armed and low, unprotected array addresses are still writable while the latch is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmdSetLatch | input | 1 | Pulse: set write-enable latch |
| cmdClrLatch | input | 1 | Pulse: clear write-enable latch |
| cmdStatusWrite | input | 1 | Pulse: commit status write |
| statusData | input | 8 | Byte carried by the status write |
| arrayWriteDone | input | 1 | Pulse: array write finished |
| busy | input | 1 | Internal write in progress |
| wpN | input | 1 | Active-low write-protect pin |
| checkAddr | input | ADDR_W | Array address to judge |
| statusByte | output | 8 | Status byte for the read command |
| arrayWritable | output | 1 | Write to `checkAddr` permitted |
| statusWritable | output | 1 | Status write permitted |

## Verification
On every cycle the assertions check the fixed zero bits and the busy mirror in the status byte, that the array is never writable without the latch or with full protection, that a clear or a write-completion drops the latch, and that a status write under an armed, low protect pin leaves the stored bits unchanged. Only the bench's scenarios show the full decode of the protected regions across every address and every block-protect setting, the complete truth table of status-write permission, the clear-over-set priority, and which data bits a status write actually lands.

// File: rtl/eeprom_guard_pkg.sv
package eeprom_guard_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadNv;
  } guard_strobe_t;

  localparam int STATUS_W = 8;
  localparam int BIT_WPEN = 7;
  localparam int BIT_BP1  = 3;
  localparam int BIT_BP0  = 2;
endpackage

// File: rtl/eeprom_guard_ctrl.sv
module eeprom_guard_ctrl
  import eeprom_guard_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              cmdSetLatch,
  input  logic              cmdClrLatch,
  input  logic              cmdStatusWrite,
  input  logic              arrayWriteDone,
  input  logic              busy,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] checkAddr,
  input  logic              wel,
  input  logic              wpen,
  input  logic [1:0]        bp,
  output guard_strobe_t     strobes,
  output logic              arrayWritable,
  output logic              statusWritable
);
  localparam int TOP = ADDR_W - 1;

  logic hwLock;
  logic inProtected;

  assign hwLock = wpen & ~wpN;

  always_comb begin
    unique case (bp)
      2'b00:   inProtected = 1'b0;
      2'b01:   inProtected = &checkAddr[TOP -: 2];
      2'b10:   inProtected = checkAddr[TOP];
      default: inProtected = 1'b1;
    endcase
  end

  assign statusWritable = wel & ~busy & ~hwLock;
  assign arrayWritable  = wel & ~busy & ~inProtected;

  always_comb begin
    strobes        = '0;
    strobes.loadNv = cmdStatusWrite & statusWritable;
    strobes.clrWel = cmdClrLatch | arrayWriteDone | strobes.loadNv;
    strobes.setWel = cmdSetLatch;
  end
endmodule

// File: rtl/eeprom_guard_dp.sv
module eeprom_guard_dp
  import eeprom_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  guard_strobe_t       strobes,
  input  logic [STATUS_W-1:0] statusData,
  input  logic                busy,
  output logic                wel,
  output logic                wpen,
  output logic [1:0]          bp,
  output logic [STATUS_W-1:0] statusByte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      wpen <= 1'b0;
      bp   <= 2'b00;
    end else begin
      if (strobes.clrWel)      wel <= 1'b0;
      else if (strobes.setWel) wel <= 1'b1;
      if (strobes.loadNv) begin
        wpen <= statusData[BIT_WPEN];
        bp   <= {statusData[BIT_BP1], statusData[BIT_BP0]};
      end
    end
  end

  assign statusByte = {wpen, 3'b000, bp, wel, busy};
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
  import eeprom_guard_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdSetLatch,
  input  logic              cmdClrLatch,
  input  logic              cmdStatusWrite,
  input  logic [7:0]        statusData,
  input  logic              arrayWriteDone,
  input  logic              busy,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] checkAddr,
  output logic [7:0]        statusByte,
  output logic              arrayWritable,
  output logic              statusWritable
);
  guard_strobe_t strobes;
  logic          wel;
  logic          wpen;
  logic [1:0]    bp;

  eeprom_guard_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .cmdSetLatch(cmdSetLatch), .cmdClrLatch(cmdClrLatch),
    .cmdStatusWrite(cmdStatusWrite), .arrayWriteDone(arrayWriteDone),
    .busy(busy), .wpN(wpN), .checkAddr(checkAddr),
    .wel(wel), .wpen(wpen), .bp(bp), .strobes(strobes),
    .arrayWritable(arrayWritable), .statusWritable(statusWritable)
  );

  eeprom_guard_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .statusData(statusData),
    .busy(busy), .wel(wel), .wpen(wpen), .bp(bp), .statusByte(statusByte)
  );

  // R1: fixed zero bits and busy mirror
  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    statusByte[6:4] == 3'b000 && statusByte[0] == busy);

  // R3: clear pulse drops the latch
  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmdClrLatch |=> !statusByte[1]);

  // R7: armed low pin freezes stored bits
  assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStatusWrite && statusByte[7] && !wpN) |=> $stable({statusByte[7], statusByte[3:2]}));

  // R8: no array permission without the latch
  assert_no_array_without_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !statusByte[1] |-> !arrayWritable);

  // R8: full protection blocks every address
  assert_all_protected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    statusByte[3:2] == 2'b11 |-> !arrayWritable);

  // R9: completion clears the latch
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arrayWriteDone |=> !statusByte[1]);
endmodule

// File: tb/eeprom_guard_bench.sv
module eeprom_guard_bench;
  localparam int ADDR_W = 11;
  localparam int NADDR  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdSetLatch = 0, cmdClrLatch = 0, cmdStatusWrite = 0, arrayWriteDone = 0;
  logic [7:0] statusData = '0;
  logic busy = 0, wpN = 1;
  logic [ADDR_W-1:0] checkAddr = '0;
  logic [7:0] statusByte;
  logic arrayWritable, statusWritable;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eeprom_guard #(.ADDR_W(ADDR_W)) u_eeprom_guard (
    .clk(clk), .rst_n(rst_n), .cmdSetLatch(cmdSetLatch), .cmdClrLatch(cmdClrLatch),
    .cmdStatusWrite(cmdStatusWrite), .statusData(statusData),
    .arrayWriteDone(arrayWriteDone), .busy(busy), .wpN(wpN), .checkAddr(checkAddr),
    .statusByte(statusByte), .arrayWritable(arrayWritable), .statusWritable(statusWritable)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 set latch, 1 clear latch, 2 status write, 3 array done, 4 set+clear
  task automatic doCmd(input int kind, input logic [7:0] d);
    @(negedge clk);
    statusData = d;
    case (kind)
      0: cmdSetLatch = 1;
      1: cmdClrLatch = 1;
      2: cmdStatusWrite = 1;
      3: arrayWriteDone = 1;
      default: begin cmdSetLatch = 1; cmdClrLatch = 1; end
    endcase
    @(negedge clk);
    cmdSetLatch = 0; cmdClrLatch = 0; cmdStatusWrite = 0; arrayWriteDone = 0;
    #1;
  endtask

  task automatic loadStatus(input logic [7:0] d);
    wpN = 1; busy = 0;
    doCmd(0, 8'h00);
    doCmd(2, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R2 reset status", statusByte, 8'h00);
    check("R2 reset arrayWritable", arrayWritable, 0);
    check("R2 reset statusWritable", statusWritable, 0);

    doCmd(0, 8'h00);
    check("R3 set latch", statusByte, 8'h02);
    doCmd(1, 8'h00);
    check("R3 clear latch", statusByte, 8'h00);
    doCmd(0, 8'h00);
    doCmd(4, 8'h00);
    check("R3 clear wins", statusByte, 8'h00);

    loadStatus(8'hFF);
    check("R6 status load ignores other bits and clears latch", statusByte, 8'h8C);
    check("R1 unused bits zero", statusByte[6:4], 3'b000);

    wpN = 0;
    doCmd(0, 8'h00);
    check("R4 set under lock", statusByte, 8'h8E);
    check("R5 locked status", statusWritable, 0);
    doCmd(2, 8'h00);
    check("R7 locked write ignored", statusByte, 8'h8E);
    doCmd(1, 8'h00);
    check("R4 clear under lock", statusByte, 8'h8C);

    loadStatus(8'h80);
    wpN = 0;
    doCmd(0, 8'h00);
    checkAddr = 11'h7FF; #1;
    check("R10 armed pin, unprotected array", arrayWritable, 1);
    check("R5 armed pin blocks status", statusWritable, 0);
    doCmd(3, 8'h00);
    check("R9 done clears latch under low pin", statusByte, 8'h80);

    // R5 full truth table
    for (int pe = 0; pe < 2; pe++) begin
      for (int we = 0; we < 2; we++) begin
        loadStatus({pe[0], 7'b0});
        doCmd(we ? 0 : 1, 8'h00);
        for (int p = 0; p < 2; p++) begin
          for (int b = 0; b < 2; b++) begin
            wpN = p[0]; busy = b[0]; #1;
            check("R5 statusWritable table", statusWritable,
                  (we == 1 && b == 0 && !(pe == 1 && p == 0)) ? 1 : 0);
            check("R1 busy mirror", statusByte[0], b[0]);
          end
        end
        busy = 0; wpN = 1;
      end
    end

    // R8 sweep of every address under each protect setting
    for (int bpv = 0; bpv < 4; bpv++) begin
      loadStatus({4'b0, bpv[1:0], 2'b00});
      check("R6 block bits stored", statusByte, {4'b0, bpv[1:0], 2'b00});
      doCmd(0, 8'h00);
      for (int a = 0; a < NADDR; a++) begin
        logic prot;
        checkAddr = a[ADDR_W-1:0]; #1;
        prot = (bpv == 1) ? (a >= 1536) : (bpv == 2) ? (a >= 1024) : (bpv == 3);
        check("R8 array permission", arrayWritable, prot ? 0 : 1);
      end
      busy = 1; checkAddr = '0; #1;
      check("R8 busy blocks array", arrayWritable, 0);
      busy = 0;
    end

    // R7 status write while busy ignored
    loadStatus(8'h00);
    doCmd(0, 8'h00);
    busy = 1;
    doCmd(2, 8'h8C);
    check("R7 busy write ignored", statusByte, 8'h03);
    busy = 0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule